// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns three asynchronous external interrupt pins into clean request flags for an interrupt controller. Every pin first passes through a two-flop synchronizer. Edges are then found by comparing the synchronized level with the sample taken one cycle earlier. The two lower pins can each be set to one of four trigger modes. The top pin only responds to edges.

Edge-triggered events set a sticky pending flag. That flag stays set until the controller pulses the pin's acknowledge input. In low-level mode there is no stored state: the request follows the synchronized pin while it is held low. A per-pin enable mask gates each request. A disabled pin does not record new edges.

Software programs a small control register through a write port. The port has three field strobes, so the enables can be written without touching the sense settings.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all requests are low and every enable is 0. Pins 0 and 1 sense a low level (code 00), and pin 2 senses falling edges (polarity 0).
- R2: Pins are synchronized by two flops, and each request is registered. A pin change driven just after one rising clock edge shows on req_o after the third rising edge, and not after the second.
- R3: Sense code 00 (low level) raises the request while the enabled synchronized pin is low. The request is not latched: it drops three cycles after the pin returns high, and acknowledge has no effect on it.
- R4: Sense code 01 (any change) latches a pending request on both a falling and a rising edge of the pin.
- R5: Sense code 10 latches a pending request on a falling edge only.
- R6: Sense code 11 latches a pending request on a rising edge only.
- R7: Pin 2 has no level mode. Its single polarity bit selects a falling edge (0) or a rising edge (1). Holding the pin at its active level does not re-raise the request after it is acknowledged.
- R8: An acknowledge pulse clears the pending edge request of its pin. If a new qualifying edge arrives in the same cycle as the acknowledge, the edge wins and the flag stays set.
- R9: An edge on a disabled pin is not recorded. Clearing the enable of a pin whose request is pending hides that request at once. Setting the enable again shows the request again.
- R10: Several edges that occur before an acknowledge collapse into one pending flag, and a single acknowledge clears it.
- R11: The control write port has three strobes. cfg_wr_i[0] loads the sense field, where pin k uses bits [2k+1:2k]. cfg_wr_i[1] loads the pin 2 polarity. cfg_wr_i[2] loads the enable mask, with one bit per pin. A field whose strobe is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Asynchronous external interrupt pins |
| cfg_wr_i | input | 3 | Field write strobes: [0] sense, [1] polarity, [2] enable |
| cfg_sense_i | input | 4 | Sense codes for pins 0 and 1 |
| cfg_pol_i | input | 1 | Edge polarity for pin 2 |
| cfg_en_i | input | 3 | Per-pin enable mask |
| ack_i | input | 3 | Per-pin acknowledge, clears the pending edge flag |
| req_o | output | 3 | Per-pin interrupt request |

## Verification
Each of the four sense codes is applied to both configurable pins with three pin patterns: a falling transition, a rising transition and a steady high level. Together these separate level-following from edge latching, and one edge direction from the other. Directed sequences then hold the pin low across an acknowledge, which shows the difference between level mode and the sticky flag. They also stack two edges before one acknowledge, make an edge coincide with an acknowledge, and toggle the enable around a pending request. Pin 2 is driven with both polarities, and the reset defaults are observed by writing only the enable field.

// File: rtl/extint_pkg.sv
package extint_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/eis_cfg_regs.sv
module eis_cfg_regs #(
    parameter int NCFG  = 2,
    parameter int NEDGE = 1,
    parameter int NPINS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         wr_i,
    input  logic [2*NCFG-1:0]  sense_i,
    input  logic [NEDGE-1:0]   pol_i,
    input  logic [NPINS-1:0]   en_i,
    output logic [2*NCFG-1:0]  sense_o,
    output logic [NEDGE-1:0]   pol_o,
    output logic [NPINS-1:0]   en_o
);
    typedef struct packed {
        logic [2*NCFG-1:0] sense;
        logic [NEDGE-1:0]  pol;
        logic [NPINS-1:0]  en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i[0]) cfg_d.sense = sense_i;
        if (wr_i[1]) cfg_d.pol   = pol_i;
        if (wr_i[2]) cfg_d.en    = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sense_o = cfg_q.sense;
    assign pol_o   = cfg_q.pol;
    assign en_o    = cfg_q.en;

    // R11: an unstrobed enable field holds its value
    a_r11_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i[2] |=> $stable(en_o));
endmodule

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
    parameter int             W    = 3,
    parameter logic [W-1:0]   IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: IDLE, s2: IDLE, prev: IDLE};
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/eis_channel.sv
module eis_channel
    import extint_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_i,
    input  logic   prev_i,
    input  sense_e mode_i,
    input  logic   en_i,
    input  logic   ack_i,
    output logic   req_o
);
    typedef struct packed {
        logic pend;
        logic lvl;
    } chan_t;

    chan_t  ch_d, ch_q;
    sense_e mode_eff;
    logic   evt;
    logic   rise, fall;

    generate
        if (LEVEL_OK) begin : g_full
            assign mode_eff = mode_i;
        end else begin : g_edge_only
            assign mode_eff = mode_i[0] ? SENSE_RISE : SENSE_FALL;
        end
    endgenerate

    always_comb begin
        rise = lvl_i & ~prev_i;
        fall = ~lvl_i & prev_i;
        unique case (mode_eff)
            SENSE_LOW:  evt = 1'b0;
            SENSE_ANY:  evt = rise | fall;
            SENSE_FALL: evt = fall;
            default:    evt = rise;
        endcase
        ch_d.lvl = (mode_eff == SENSE_LOW) & ~lvl_i;
        if (mode_eff == SENSE_LOW) ch_d.pend = 1'b0;
        else                       ch_d.pend = (en_i & evt) | (ch_q.pend & ~ack_i);
        req_o = en_i & ((mode_eff == SENSE_LOW) ? ch_q.lvl : ch_q.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // R8: acknowledge without a coincident edge clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(en_i && evt)) |=> !ch_q.pend);
    // R8: a qualifying edge always leaves the flag set
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && evt) |=> ch_q.pend);
    // R9: a disabled pin cannot create a pending flag
    a_r9_no_latch_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !ch_q.pend) |=> !ch_q.pend);
    // R3: level mode keeps no sticky state
    a_r3_level_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == SENSE_LOW) |=> !ch_q.pend);

    generate
        if (!LEVEL_OK) begin : g_chk_edge
            // R7: the edge-only channel never produces a level request
            a_r7_no_level: assert property (@(posedge clk) disable iff (!rst_n)
                $past(lvl_i == 1'b0) |-> !ch_q.lvl);
        end
    endgenerate
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 3,
    parameter int NUM_CFG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [2:0]            cfg_wr_i,
    input  logic [2*NUM_CFG-1:0]  cfg_sense_i,
    input  logic [NUM_PINS-NUM_CFG-1:0] cfg_pol_i,
    input  logic [NUM_PINS-1:0]   cfg_en_i,
    input  logic [NUM_PINS-1:0]   ack_i,
    output logic [NUM_PINS-1:0]   req_o
);
    localparam int NEDGE = NUM_PINS - NUM_CFG;

    logic [2*NUM_CFG-1:0] sense_q;
    logic [NEDGE-1:0]     pol_q;
    logic [NUM_PINS-1:0]  en_q;
    logic [NUM_PINS-1:0]  lvl_s, prev_s;

    eis_cfg_regs #(.NCFG(NUM_CFG), .NEDGE(NEDGE), .NPINS(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .sense_i (cfg_sense_i),
        .pol_i   (cfg_pol_i),
        .en_i    (cfg_en_i),
        .sense_o (sense_q),
        .pol_o   (pol_q),
        .en_o    (en_q)
    );

    eis_pin_sync #(.W(NUM_PINS), .IDLE({NUM_PINS{1'b1}})) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl_s),
        .prev_o (prev_s)
    );

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
            if (k < NUM_CFG) begin : g_cfg
                eis_channel #(.LEVEL_OK(1'b1)) u_ch (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .lvl_i  (lvl_s[k]),
                    .prev_i (prev_s[k]),
                    .mode_i (sense_e'(sense_q[2*k +: 2])),
                    .en_i   (en_q[k]),
                    .ack_i  (ack_i[k]),
                    .req_o  (req_o[k])
                );
            end else begin : g_edge
                eis_channel #(.LEVEL_OK(1'b0)) u_ch (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .lvl_i  (lvl_s[k]),
                    .prev_i (prev_s[k]),
                    .mode_i (pol_q[k-NUM_CFG] ? SENSE_RISE : SENSE_FALL),
                    .en_i   (en_q[k]),
                    .ack_i  (ack_i[k]),
                    .req_o  (req_o[k])
                );
            end
        end
    endgenerate

    // R9: no request leaves a masked pin
    a_r9_mask_out: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o & ~en_q) == '0);
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_i = 3'b111;
    logic [2:0] cfg_wr_i = '0;
    logic [3:0] cfg_sense_i = '0;
    logic [0:0] cfg_pol_i = '0;
    logic [2:0] cfg_en_i = '0;
    logic [2:0] ack_i = '0;
    logic [2:0] req_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_sense u_ext_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_wr_i(cfg_wr_i),
        .cfg_sense_i(cfg_sense_i), .cfg_pol_i(cfg_pol_i), .cfg_en_i(cfg_en_i),
        .ack_i(ack_i), .req_o(req_o)
    );

    // {mode[1:0], pin before, pin after, expected request}
    localparam logic [4:0] VEC [12] = '{
        {2'b00, 1'b1, 1'b0, 1'b1}, {2'b00, 1'b0, 1'b1, 1'b0}, {2'b00, 1'b1, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1}, {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0}, {2'b10, 1'b1, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b0}, {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b1, 1'b0}
    };
    localparam string VREQ [4] = '{"R3", "R4", "R5", "R6"};

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: req got=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wcfg(input logic [2:0] we, input logic [3:0] s,
                        input logic p, input logic [2:0] e);
        @(negedge clk);
        cfg_wr_i = we; cfg_sense_i = s; cfg_pol_i = p; cfg_en_i = e;
        @(negedge clk);
        cfg_wr_i = '0;
    endtask

    task automatic ack_pulse(input logic [2:0] a);
        ack_i = a;
        @(negedge clk);
        ack_i = '0;
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1: idle after reset
        chk("R1", req_o[0], 1'b0); chk("R1", req_o[1], 1'b0); chk("R1", req_o[2], 1'b0);
        // R1 R11: writing only enables keeps default sense and polarity
        wcfg(3'b100, 4'b1111, 1'b1, 3'b111);
        chk("R1", req_o[0], 1'b0);
        pin_i = 3'b010; // pin0 low (level), pin2 low (falling)
        wait_n(3);
        chk("R1", req_o[0], 1'b1);
        chk("R1", req_o[2], 1'b1);
        chk("R11", req_o[1], 1'b0);
        pin_i = 3'b111;
        wait_n(3);
        ack_pulse(3'b111);
        chk("R1", req_o[0], 1'b0);

        // table walk over both configurable pins
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 12; v++) begin
                logic [3:0] s;
                s = '0;
                s[2*p +: 2] = VEC[v][4:3];
                wcfg(3'b101, s, 1'b0, 3'b111);
                pin_i[p] = VEC[v][2];
                wait_n(4);
                ack_pulse(3'b111);
                pin_i[p] = VEC[v][1];
                wait_n(3);
                chk(VREQ[VEC[v][4:3]], req_o[p], VEC[v][0]);
            end
        end
        pin_i = 3'b111;
        wcfg(3'b101, 4'b1010, 1'b0, 3'b111);
        wait_n(4);
        ack_pulse(3'b111);

        // R2: latency, falling mode on pin0
        pin_i[0] = 1'b0;
        wait_n(2);
        chk("R2", req_o[0], 1'b0);
        wait_n(1);
        chk("R2", req_o[0], 1'b1);

        // R10: second edge before ack collapses into one flag
        pin_i[0] = 1'b1; wait_n(3);
        pin_i[0] = 1'b0; wait_n(3);
        chk("R10", req_o[0], 1'b1);
        ack_pulse(3'b001);
        chk("R10", req_o[0], 1'b0);

        // R8: edge and ack in the same cycle, edge wins
        pin_i[0] = 1'b1; wait_n(4);
        pin_i[0] = 1'b0;
        wait_n(2);
        ack_i = 3'b001;
        @(negedge clk);
        ack_i = '0;
        chk("R8", req_o[0], 1'b1);
        ack_pulse(3'b001);
        chk("R8", req_o[0], 1'b0);

        // R9: disabled pin does not record the edge
        pin_i[0] = 1'b1; wait_n(4);
        wcfg(3'b100, 4'b0, 1'b0, 3'b110);
        pin_i[0] = 1'b0; wait_n(4);
        wcfg(3'b100, 4'b0, 1'b0, 3'b111);
        chk("R9", req_o[0], 1'b0);
        // R9: mask hides and restores a pending flag
        pin_i[0] = 1'b1; wait_n(4);
        pin_i[0] = 1'b0; wait_n(3);
        chk("R9", req_o[0], 1'b1);
        wcfg(3'b100, 4'b0, 1'b0, 3'b110);
        chk("R9", req_o[0], 1'b0);
        wcfg(3'b100, 4'b0, 1'b0, 3'b111);
        chk("R9", req_o[0], 1'b1);
        ack_pulse(3'b001);

        // R3: level mode, ack ignored, released three cycles after pin high
        wcfg(3'b001, 4'b0000, 1'b0, 3'b111);
        wait_n(3);
        chk("R3", req_o[0], 1'b1);
        ack_pulse(3'b001);
        chk("R3", req_o[0], 1'b1);
        pin_i[0] = 1'b1;
        wait_n(2);
        chk("R3", req_o[0], 1'b1);
        wait_n(1);
        chk("R3", req_o[0], 1'b0);

        // R7: pin2 falling, held low, no re-raise after ack
        pin_i[2] = 1'b0; wait_n(3);
        chk("R7", req_o[2], 1'b1);
        ack_pulse(3'b100);
        wait_n(5);
        chk("R7", req_o[2], 1'b0);
        pin_i[2] = 1'b1; wait_n(3);
        chk("R7", req_o[2], 1'b0);
        // R7 R11: polarity 1 selects rising edge
        wcfg(3'b010, 4'b0, 1'b1, 3'b0);
        pin_i[2] = 1'b0; wait_n(4);
        chk("R7", req_o[2], 1'b0);
        pin_i[2] = 1'b1; wait_n(3);
        chk("R7", req_o[2], 1'b1);
        ack_pulse(3'b100);
        chk("R7", req_o[2], 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule